// File: doc/BRIEF.md
# Three-Stage Prefetch Pipeline Sequencer

This block moves instructions through three stages: fetch, decode and execute. It holds the program counter and drives it as the instruction fetch address. On each cycle that is not stalled it places the returned word in a decode register. On the next such cycle the word moves on into an execute register. Each stage carries a valid bit in place of real decode or datapath work. The block also reports the byte address of the instruction in execute. Because the counter always points at the instruction being fetched, that address is the counter minus two instruction sizes.

The block supports two instruction widths. In wide state each instruction is 32 bits and the counter steps by 4 bytes. In narrow state each instruction is 16 bits and the counter steps by 2 bytes. The state changes only when a branch is taken. A branch taken from execute loads an aligned target and the state that goes with it. It also empties the decode and execute stages, so the pipeline refills from the target. A stall input holds every register as it is.

Top module: `prefetch_seq`

## Requirements
- R1: While the internal reset is active, and after it releases, the counter is 0, both valid bits are 0 and the state is wide. The internal reset leaves reset on the second rising clock edge after `rst_n` goes high.
- R2: `fetch_addr_o` always equals `pc_o`. Each unstalled cycle without a taken branch adds 4 to the counter in wide state (`narrow_o`=0) and 2 in narrow state (`narrow_o`=1).
- R3: Each unstalled cycle captures the word at the fetch address into decode, with decode valid set. In the same cycle the old decode contents move into execute. A word therefore reaches execute two unstalled edges after it is fetched, and a full pipeline delivers one instruction per cycle.
- R4: While execute is valid, `ex_addr_o` equals `pc_o - 8` in wide state and `pc_o - 4` in narrow state.
- R5: A branch is taken when `br_take_i`=1, `stall_i`=0 and execute is valid. At that edge the counter loads the aligned `br_target_i`, the state becomes `br_narrow_i`, and both valid bits clear.
- R6: After a taken branch, execute stays invalid for exactly two unstalled cycles. It then holds the word at the target address.
- R7: The fetch address has bits 1:0 at zero in wide state and bit 0 at zero in narrow state. The low target bits are dropped to achieve this.
- R8: While `stall_i`=1, the counter, the state, both stage words and both valid bits hold their values. This holds even if `br_take_i` is set.
- R9: A branch request while execute is invalid has no effect. The counter keeps stepping and the stages keep filling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze all pipeline state |
| br_take_i | input | 1 | Branch in execute wants to load a target |
| br_target_i | input | AW (32) | Branch target byte address |
| br_narrow_i | input | 1 | State for the target: 1 = 16-bit, 0 = 32-bit |
| fetch_addr_o | output | AW (32) | Instruction fetch address |
| fetch_data_i | input | IW (32) | Word returned for the fetch address, same cycle |
| dec_valid_o | output | 1 | Decode stage holds an instruction |
| dec_word_o | output | IW (32) | Decode stage word |
| ex_valid_o | output | 1 | Execute stage holds an instruction |
| ex_word_o | output | IW (32) | Execute stage word |
| ex_addr_o | output | AW (32) | Address of the executing instruction |
| pc_o | output | AW (32) | Architectural program counter |
| narrow_o | output | 1 | Current state: 1 = 16-bit, 0 = 32-bit |

## Verification
A wrong counter value shows on `fetch_addr_o` in the same cycle. It shows on `ex_addr_o` no later than the next check of a valid execute word, because every fetched word is a known function of its address. A stage register that loses its contents or valid bit is caught two unstalled edges later, when `ex_word_o` no longer matches the word at `ex_addr_o`. A flush that clears too few slots, or one that gets the state wrong, shows as a wrong valid bit or address within the two-cycle refill window. The bench sweeps every branch target in a small range, in both states, with and without stalls, against an arithmetic model.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic {
    ST_WIDE   = 1'b0,
    ST_NARROW = 1'b1
  } istate_e;

  // bytes consumed by one instruction in the given state
  function automatic logic [2:0] step_bytes(istate_e st);
    return (st == ST_NARROW) ? 3'd2 : 3'd4;
  endfunction

  // distance from the fetch counter back to the executing instruction
  function automatic logic [3:0] ex_lag_bytes(istate_e st);
    return (st == ST_NARROW) ? 4'd4 : 4'd8;
  endfunction

endpackage

// File: rtl/pf_rst_sync.sv
module pf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/pf_pc_unit.sv
module pf_pc_unit
  import pf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic          load_narrow_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output istate_e       st_o
);
  logic [AW-1:0] pc_q, pc_d;
  istate_e       st_q, st_d;
  istate_e       load_st;
  logic [AW-1:0] target_al;

  assign load_st   = load_narrow_i ? ST_NARROW : ST_WIDE;
  assign target_al = (load_st == ST_NARROW) ? {target_i[AW-1:1], 1'b0}
                                            : {target_i[AW-1:2], 2'b00};

  always_comb begin
    pc_d = pc_q;
    st_d = st_q;
    if (load_i) begin
      pc_d = target_al;
      st_d = load_st;
    end else begin
      pc_d = pc_q + AW'(step_bytes(st_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      st_q <= ST_WIDE;
    end else if (adv_i) begin
      pc_q <= pc_d;
      st_q <= st_d;
    end
  end

  assign pc_o = pc_q;
  assign st_o = st_q;

  // R7
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WIDE) |-> (pc_q[1:0] == 2'b00));
  // R7
  narrow_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);
  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> ($stable(pc_q) && $stable(st_q)));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && st_q == ST_WIDE) |=> (pc_q == $past(pc_q) + AW'(4)));
endmodule

// File: rtl/pf_stage_reg.sv
module pf_stage_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         flush_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_word_i,
  output logic         valid_o,
  output logic [W-1:0] word_o
);
  logic         valid_q, valid_d;
  logic [W-1:0] word_q,  word_d;

  always_comb begin
    valid_d = in_valid_i & ~flush_i;
    word_d  = in_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (adv_i) begin
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;

  // R8
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> ($stable(valid_q) && $stable(word_q)));
  // R5
  stage_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && flush_i) |=> !valid_q);
endmodule

// File: rtl/prefetch_seq.sv
module prefetch_seq
  import pf_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          br_take_i,
  input  logic [AW-1:0] br_target_i,
  input  logic          br_narrow_i,
  output logic [AW-1:0] fetch_addr_o,
  input  logic [IW-1:0] fetch_data_i,
  output logic          dec_valid_o,
  output logic [IW-1:0] dec_word_o,
  output logic          ex_valid_o,
  output logic [IW-1:0] ex_word_o,
  output logic [AW-1:0] ex_addr_o,
  output logic [AW-1:0] pc_o,
  output logic          narrow_o
);
  logic          rst_int_n;
  logic          adv;
  logic          flush;
  logic [AW-1:0] pc;
  istate_e       st;
  logic          dec_v, ex_v;
  logic [IW-1:0] dec_w, ex_w;

  pf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign adv   = ~stall_i;
  assign flush = adv & br_take_i & ex_v;

  pf_pc_unit #(.AW(AW)) u_pc (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .adv_i         (adv),
    .load_i        (flush),
    .load_narrow_i (br_narrow_i),
    .target_i      (br_target_i),
    .pc_o          (pc),
    .st_o          (st)
  );

  pf_stage_reg #(.W(IW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .adv_i      (adv),
    .flush_i    (flush),
    .in_valid_i (1'b1),
    .in_word_i  (fetch_data_i),
    .valid_o    (dec_v),
    .word_o     (dec_w)
  );

  pf_stage_reg #(.W(IW)) u_ex (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .adv_i      (adv),
    .flush_i    (flush),
    .in_valid_i (dec_v),
    .in_word_i  (dec_w),
    .valid_o    (ex_v),
    .word_o     (ex_w)
  );

  assign fetch_addr_o = pc;
  assign pc_o         = pc;
  assign narrow_o     = (st == ST_NARROW);
  assign dec_valid_o  = dec_v;
  assign dec_word_o   = dec_w;
  assign ex_valid_o   = ex_v;
  assign ex_word_o    = ex_w;
  assign ex_addr_o    = pc - AW'(ex_lag_bytes(st));

  // R3
  ex_follows_dec_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv && !flush && dec_v) |=> (ex_v && ex_w == $past(dec_w)));
  // R6
  refill_gap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv && $past(flush)) |=> !ex_v);
  // R9
  no_branch_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv && br_take_i && !ex_v) |=> dec_v);
endmodule

// File: tb/prefetch_seq_tb.sv
module prefetch_seq_tb;
  localparam int AW = 32;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall_i = 1'b0;
  logic          br_take_i = 1'b0;
  logic [AW-1:0] br_target_i = '0;
  logic          br_narrow_i = 1'b0;
  logic [AW-1:0] fetch_addr_o;
  logic [IW-1:0] fetch_data_i;
  logic          dec_valid_o, ex_valid_o, narrow_o;
  logic [IW-1:0] dec_word_o, ex_word_o;
  logic [AW-1:0] ex_addr_o, pc_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [AW-1:0] m_pc;
  logic          m_nar, m_dv, m_ev;
  logic [IW-1:0] m_dw, m_ew;

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] mem_f(logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  assign fetch_data_i = mem_f(fetch_addr_o);

  prefetch_seq #(.AW(AW), .IW(IW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_i      (stall_i),
    .br_take_i    (br_take_i),
    .br_target_i  (br_target_i),
    .br_narrow_i  (br_narrow_i),
    .fetch_addr_o (fetch_addr_o),
    .fetch_data_i (fetch_data_i),
    .dec_valid_o  (dec_valid_o),
    .dec_word_o   (dec_word_o),
    .ex_valid_o   (ex_valid_o),
    .ex_word_o    (ex_word_o),
    .ex_addr_o    (ex_addr_o),
    .pc_o         (pc_o),
    .narrow_o     (narrow_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 fetch addr", 64'(fetch_addr_o), 64'(m_pc));
    chk("R2 pc", 64'(pc_o), 64'(m_pc));
    chk("R5 state", 64'(narrow_o), 64'(m_nar));
    chk("R3 dec valid", 64'(dec_valid_o), 64'(m_dv));
    if (m_dv) chk("R3 dec word", 64'(dec_word_o), 64'(m_dw));
    chk("R3 ex valid", 64'(ex_valid_o), 64'(m_ev));
    if (m_ev) begin
      chk("R3 ex word", 64'(ex_word_o), 64'(m_ew));
      chk("R4 ex addr", 64'(ex_addr_o), 64'(m_pc - (m_nar ? 32'd4 : 32'd8)));
      chk("R4 ex word at addr", 64'(ex_word_o), 64'(mem_f(ex_addr_o)));
    end
    if (m_nar) chk("R7 narrow align", 64'(fetch_addr_o[0]), 64'd0);
    else       chk("R7 wide align", 64'(fetch_addr_o[1:0]), 64'd0);
  endtask

  // one clock: drive, edge, update model, sample 2 ns later
  task automatic cyc(logic st, logic br, logic [AW-1:0] tgt, logic nar);
    stall_i     = st;
    br_take_i   = br;
    br_target_i = tgt;
    br_narrow_i = nar;
    @(posedge clk);
    if (!st) begin
      if (br && m_ev) begin
        m_pc  = nar ? {tgt[AW-1:1], 1'b0} : {tgt[AW-1:2], 2'b00};
        m_nar = nar;
        m_dv  = 1'b0;
        m_ev  = 1'b0;
      end else begin
        m_ev  = m_dv;
        m_ew  = m_dw;
        m_dv  = 1'b1;
        m_dw  = mem_f(m_pc);
        m_pc  = m_pc + (m_nar ? 32'd2 : 32'd4);
      end
    end
    #2;
    compare_all();
  endtask

  task automatic fill_until_ex();
    for (int k = 0; k < 4 && !m_ev; k++) cyc(1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    m_pc = '0; m_nar = 1'b0; m_dv = 1'b0; m_ev = 1'b0; m_dw = '0; m_ew = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: state held in reset
    chk("R1 pc in reset", 64'(pc_o), 64'd0);
    chk("R1 dec valid in reset", 64'(dec_valid_o), 64'd0);
    chk("R1 ex valid in reset", 64'(ex_valid_o), 64'd0);
    chk("R1 wide in reset", 64'(narrow_o), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    // R1: still reset state after synchronous release
    chk("R1 pc after release", 64'(pc_o), 64'd0);
    chk("R1 valid after release", 64'({dec_valid_o, ex_valid_o}), 64'd0);

    // R3: free run, latency and throughput in wide state
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, '0, 1'b0);

    // R5 R6 R7: sweep targets in both states, unaligned targets included
    for (int nar = 0; nar < 2; nar++) begin
      for (int t = 0; t < 64; t++) begin
        logic [AW-1:0] tgt;
        tgt = 32'h0000_0100 + 32'(t);
        fill_until_ex();
        cyc(1'b0, 1'b1, tgt, 1'(nar));
        // R6: two cycles with execute invalid, then the target word
        chk("R6 gap0", 64'(ex_valid_o), 64'd0);
        cyc(1'b0, 1'b0, '0, 1'b0);
        chk("R6 gap1", 64'(ex_valid_o), 64'd0);
        cyc(1'b0, 1'b0, '0, 1'b0);
        chk("R6 target arrives", 64'(ex_valid_o), 64'd1);
        chk("R6 target addr", 64'(ex_addr_o),
            64'(nar != 0 ? {tgt[AW-1:1], 1'b0} : {tgt[AW-1:2], 2'b00}));
        cyc(1'b0, 1'b0, '0, 1'b0);
      end
    end

    // R9: branch requests while execute is invalid are ignored
    for (int nar = 0; nar < 2; nar++) begin
      fill_until_ex();
      cyc(1'b0, 1'b1, 32'h0000_2000, 1'(nar));
      cyc(1'b0, 1'b1, 32'h0000_3000, 1'b1);   // R9 ex invalid here
      chk("R9 no second load", 64'(pc_o), 64'(32'h0000_2000 + (nar != 0 ? 32'd2 : 32'd4)));
      cyc(1'b0, 1'b1, 32'h0000_3000, 1'b1);   // R9 ex still invalid
      cyc(1'b0, 1'b0, '0, 1'b0);
    end

    // R8: all stall patterns over five cycles, with and without branch request
    for (int nar = 0; nar < 2; nar++) begin
      for (int pat = 0; pat < 32; pat++) begin
        fill_until_ex();
        cyc(1'b0, 1'b1, 32'h0000_4000 + 32'(pat * 6), 1'(nar));
        for (int b = 0; b < 5; b++) begin
          logic [AW-1:0] pc_before;
          pc_before = pc_o;
          cyc(1'(pat >> b), 1'(b == 4), 32'h0000_5000, 1'(nar));
          if (((pat >> b) & 1) != 0)
            chk("R8 stall holds pc", 64'(pc_o), 64'(pc_before));
        end
      end
    end

    // R2: long narrow run
    fill_until_ex();
    cyc(1'b0, 1'b1, 32'h0000_7FFE, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, '0, 1'b0);

    // R1: reset again mid-run
    rst_n = 1'b0;
    #2;
    chk("R1 async reset pc", 64'(pc_o), 64'd0);
    chk("R1 async reset valid", 64'({dec_valid_o, ex_valid_o}), 64'd0);
    chk("R1 async reset state", 64'(narrow_o), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule